// File: doc/BRIEF.md
# Oversampled Serial Receiver With Line-Break Detection

This block receives asynchronous serial characters on a single input line. It samples the line once per oversampling tick, at sixteen ticks per bit by default, and confirms each start bit by a majority vote. It then assembles eight data bits, least significant first, an optional parity bit and one stop bit. Each character is presented with a one-cycle valid pulse, together with framing and parity error indications.

The receiver also recognises a line break. A break is a frame in which the data bits, the parity bit (when enabled) and the stop bit are all low. A break is not reported as a character or as a framing error. Instead, it raises a sticky break flag at the stop-bit sample. While the break lasts, the receiver ignores the line. When the line returns high, the end of the break raises the flag a second time, so that software can count both edges of the break.

The end of a break is found in one of two ways. In the default mode the line must be high for two consecutive oversampling ticks. In the alternative mode a single high sample is enough. The baud tick generator and all register access sit outside this block.

Top module: `uart_brk_rx`

## Requirements
- R1: After reset, rx_valid, frame_err, par_err and brk_flag are 0 and rx_data is 0x00. The line passes through a two-stage synchroniser that resets high. An output decided on a tick cycle changes at the next clock edge.
- R2: The start bit is detected on the first tick at which the synchronised line is low; that tick has index 0. The start is confirmed by a majority over the samples at tick indices 7, 8 and 9. If two or more of those samples are high, the receiver returns to idle and produces no output.
- R3: Each data bit is sampled at tick index 8 of its 16-tick bit period. Bits arrive least significant first. A completed character drives rx_data and pulses rx_valid high for exactly one clock.
- R4: When par_en is 1, one parity bit follows the data. par_odd = 0 selects even parity and par_odd = 1 selects odd parity. par_err is 1 when the received parity bit differs from the XOR of the data bits XOR par_odd. par_err is 0 when par_en is 0.
- R5: The stop bit is sampled at tick index 8. If it is low and the frame is not a break, the character is still delivered with rx_valid, and frame_err is 1. A high stop bit gives frame_err = 0.
- R6: A frame with data 0x00, a low parity bit (if parity is enabled) and a low stop bit is a break. It produces no rx_valid. It forces frame_err and par_err to 0, and it sets brk_flag.
- R7: While a break is in progress, no start bit is accepted and no rx_valid pulse is produced.
- R8: With sync_mode = 0, the break ends on the second consecutive tick that samples the line high. A single high tick followed by a low tick does not end it.
- R9: With sync_mode = 1, the break ends on the first tick that samples the line high.
- R10: The end of a break sets brk_flag again. The receiver then returns to idle and accepts new characters.
- R11: brk_flag is sticky and is cleared by stat_clr. If stat_clr and a break event occur in the same cycle, brk_flag is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Oversampling tick, one clock wide, 16 per bit |
| rxd_in | input | 1 | Asynchronous serial line, idle high |
| par_en | input | 1 | 1: a parity bit follows the data |
| par_odd | input | 1 | Parity sense: 0 even, 1 odd |
| sync_mode | input | 1 | 1: a single high sample ends a break |
| stat_clr | input | 1 | Clears the break flag |
| rx_data | output | 8 | Last received character |
| rx_valid | output | 1 | One-clock pulse when rx_data is new |
| frame_err | output | 1 | Stop bit of the last character was low |
| par_err | output | 1 | Parity mismatch on the last character |
| brk_flag | output | 1 | Sticky break start / break end indication |

## Verification
The bench sends an all-zero frame whose parity bit is set. A design that keys the break on the stop bit and data alone would call this frame a break, where it should be a character with a framing error. The bench also sends a start glitch that is shorter than the vote window. A receiver without the vote would deliver a phantom character.

During a break, a one-tick high pulse must not end the break in the default mode but must end it in the alternative mode. Holding the status clear high across a break edge shows whether the new event wins. A reference model compares every output on every clock, so a receiver whose timing is off by one tick is reported at once.

// File: rtl/uart_brk_pkg.sv
package uart_brk_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_BRK
  } rx_state_t;
endpackage

// File: rtl/uart_brk_sync.sv
module uart_brk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/uart_brk_flag.sv
module uart_brk_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_ev,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)         flag <= 1'b0;
    else if (set_ev) flag <= 1'b1;
    else if (clr)    flag <= 1'b0;
  end
endmodule

// File: rtl/uart_brk_framer.sv
module uart_brk_framer
  import uart_brk_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int OSR           = 16,
  parameter int BRK_END_TICKS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              rxd,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              sync_mode,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              frame_err,
  output logic              par_err,
  output logic              brk_start,
  output logic              brk_end,
  output logic              in_brk
);
  localparam int CNT_W = $clog2(OSR);
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int HI_W  = $clog2(BRK_END_TICKS + 1);
  localparam logic [CNT_W-1:0] MID    = CNT_W'(OSR / 2);
  localparam logic [CNT_W-1:0] VOTE_A = CNT_W'(OSR / 2 - 1);
  localparam logic [CNT_W-1:0] VOTE_C = CNT_W'(OSR / 2 + 1);
  localparam logic [CNT_W-1:0] LAST   = CNT_W'(OSR - 1);
  localparam logic [IDX_W-1:0] LASTB  = IDX_W'(DATA_W - 1);
  localparam logic [HI_W-1:0]  HI_LIM = HI_W'(BRK_END_TICKS - 1);

  rx_state_t         state;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  bit_idx;
  logic [1:0]        votes;
  logic [DATA_W-1:0] shreg;
  logic              pbit;
  logic [HI_W-1:0]   hi_cnt;

  logic [1:0] vote_sum;
  logic       stop_now;
  logic       zero_frame;
  logic       par_bad;

  always_comb begin
    vote_sum   = votes + {1'b0, rxd};
    stop_now   = tick && (state == ST_STOP) && (cnt == MID);
    zero_frame = (shreg == '0) && !(par_en && pbit) && !rxd;
    par_bad    = par_en && (pbit != ((^shreg) ^ par_odd));
    brk_start  = stop_now && zero_frame;
    brk_end    = tick && (state == ST_BRK) && rxd &&
                 (sync_mode || (hi_cnt == HI_LIM));
    in_brk     = (state == ST_BRK);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      bit_idx   <= '0;
      votes     <= '0;
      shreg     <= '0;
      pbit      <= 1'b0;
      hi_cnt    <= '0;
      rx_data   <= '0;
      rx_valid  <= 1'b0;
      frame_err <= 1'b0;
      par_err   <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (tick) begin
        unique case (state)
          ST_IDLE: begin
            if (!rxd) begin
              state <= ST_START;
              cnt   <= CNT_W'(1);
              votes <= '0;
            end
          end
          ST_START: begin
            if (cnt == VOTE_A || cnt == MID) votes <= vote_sum;
            if (cnt == VOTE_C && vote_sum >= 2'd2) begin
              state <= ST_IDLE;
              cnt   <= '0;
            end else if (cnt == LAST) begin
              state   <= ST_DATA;
              cnt     <= '0;
              bit_idx <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_DATA: begin
            if (cnt == MID) shreg <= {rxd, shreg[DATA_W-1:1]};
            if (cnt == LAST) begin
              cnt <= '0;
              if (bit_idx == LASTB) state <= par_en ? ST_PAR : ST_STOP;
              else                  bit_idx <= bit_idx + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_PAR: begin
            if (cnt == MID) pbit <= rxd;
            if (cnt == LAST) begin
              cnt   <= '0;
              state <= ST_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_STOP: begin
            if (cnt == MID) begin
              cnt <= '0;
              if (zero_frame) begin
                state     <= ST_BRK;
                hi_cnt    <= '0;
                frame_err <= 1'b0;
                par_err   <= 1'b0;
              end else begin
                state     <= ST_IDLE;
                rx_valid  <= 1'b1;
                rx_data   <= shreg;
                frame_err <= !rxd;
                par_err   <= par_bad;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_BRK: begin
            if (brk_end) begin
              state  <= ST_IDLE;
              hi_cnt <= '0;
            end else if (rxd) begin
              hi_cnt <= hi_cnt + 1'b1;
            end else begin
              hi_cnt <= '0;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_brk_rx.sv
module uart_brk_rx #(
  parameter int DATA_W        = 8,
  parameter int OSR           = 16,
  parameter int SYNC_STAGES   = 2,
  parameter int BRK_END_TICKS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick16,
  input  logic              rxd_in,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              sync_mode,
  input  logic              stat_clr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              frame_err,
  output logic              par_err,
  output logic              brk_flag
);
  logic rxd_s;
  logic brk_start;
  logic brk_end;
  logic brk_set;
  logic in_brk;

  uart_brk_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (rxd_in),
    .dout (rxd_s)
  );

  uart_brk_framer #(
    .DATA_W        (DATA_W),
    .OSR           (OSR),
    .BRK_END_TICKS (BRK_END_TICKS)
  ) i_framer (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick16),
    .rxd       (rxd_s),
    .par_en    (par_en),
    .par_odd   (par_odd),
    .sync_mode (sync_mode),
    .rx_data   (rx_data),
    .rx_valid  (rx_valid),
    .frame_err (frame_err),
    .par_err   (par_err),
    .brk_start (brk_start),
    .brk_end   (brk_end),
    .in_brk    (in_brk)
  );

  assign brk_set = brk_start | brk_end;

  uart_brk_flag i_flag (
    .clk    (clk),
    .rst    (rst),
    .set_ev (brk_set),
    .clr    (stat_clr),
    .flag   (brk_flag)
  );
endmodule

// File: rtl/uart_brk_rx_chk.sv
module uart_brk_rx_chk (
  input logic clk,
  input logic rst,
  input logic stat_clr,
  input logic rx_valid,
  input logic frame_err,
  input logic brk_flag,
  input logic brk_set,
  input logic in_brk
);
  a_r3_valid_single: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  a_r5_fe_with_valid: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_err) |-> rx_valid);

  a_r6_break_not_framing: assert property (@(posedge clk) disable iff (rst)
    $rose(brk_flag) |-> !frame_err);

  a_r7_quiet_in_break: assert property (@(posedge clk) disable iff (rst)
    in_brk |-> !rx_valid);

  a_r11_event_wins: assert property (@(posedge clk) disable iff (rst)
    brk_set |=> brk_flag);

  a_r11_clear_works: assert property (@(posedge clk) disable iff (rst)
    (stat_clr && !brk_set) |=> !brk_flag);
endmodule

bind uart_brk_rx uart_brk_rx_chk i_chk (
  .clk       (clk),
  .rst       (rst),
  .stat_clr  (stat_clr),
  .rx_valid  (rx_valid),
  .frame_err (frame_err),
  .brk_flag  (brk_flag),
  .brk_set   (brk_set),
  .in_brk    (in_brk)
);

// File: tb/test_uart_brk_rx.sv
module test_uart_brk_rx;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick16 = 1'b0;
  logic       rxd_in = 1'b1;
  logic       par_en = 1'b0;
  logic       par_odd = 1'b0;
  logic       sync_mode = 1'b0;
  logic       stat_clr = 1'b0;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic       frame_err;
  logic       par_err;
  logic       brk_flag;

  int n_checks = 0;
  int n_errors = 0;
  bit cmp_on = 1'b0;
  bit finished = 1'b0;

  uart_brk_rx i_uart_brk_rx (
    .clk       (clk),
    .rst       (rst),
    .tick16    (tick16),
    .rxd_in    (rxd_in),
    .par_en    (par_en),
    .par_odd   (par_odd),
    .sync_mode (sync_mode),
    .stat_clr  (stat_clr),
    .rx_data   (rx_data),
    .rx_valid  (rx_valid),
    .frame_err (frame_err),
    .par_err   (par_err),
    .brk_flag  (brk_flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    int tc = 0;
    forever begin
      @(negedge clk);
      tc++;
      tick16 = (tc % TICK_DIV == 0);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  int         m_st, m_cnt, m_votes, m_bit, m_hi;
  logic [7:0] m_shift, m_data;
  logic       m_pbit, m_s1, m_s2, m_valid, m_fe, m_pe, m_flag;

  always @(posedge clk) begin
    bit ev;
    if (rst) begin
      m_st = 0; m_cnt = 0; m_votes = 0; m_bit = 0; m_hi = 0;
      m_shift = 0; m_data = 0; m_pbit = 0; m_s1 = 1; m_s2 = 1;
      m_valid = 0; m_fe = 0; m_pe = 0; m_flag = 0;
    end else begin
      ev = 0;
      m_valid = 0;
      if (tick16) begin
        case (m_st)
          0: if (!m_s2) begin m_st = 1; m_cnt = 1; m_votes = 0; end
          1: begin
            if (m_cnt >= 7 && m_cnt <= 9) m_votes += int'(m_s2);
            if (m_cnt == 9 && m_votes >= 2) begin m_st = 0; m_cnt = 0; end
            else if (m_cnt == 15) begin m_st = 2; m_cnt = 0; m_bit = 0; end
            else m_cnt++;
          end
          2: begin
            if (m_cnt == 8) m_shift[m_bit] = m_s2;
            if (m_cnt == 15) begin
              m_cnt = 0;
              if (m_bit == 7) m_st = par_en ? 3 : 4;
              else m_bit++;
            end else m_cnt++;
          end
          3: begin
            if (m_cnt == 8) m_pbit = m_s2;
            if (m_cnt == 15) begin m_cnt = 0; m_st = 4; end
            else m_cnt++;
          end
          4: begin
            if (m_cnt == 8) begin
              m_cnt = 0;
              if (m_shift == 0 && !(par_en && m_pbit) && !m_s2) begin
                ev = 1; m_fe = 0; m_pe = 0; m_st = 5; m_hi = 0;
              end else begin
                m_valid = 1; m_data = m_shift; m_fe = !m_s2;
                m_pe = par_en && (m_pbit != ((^m_shift) ^ par_odd));
                m_st = 0;
              end
            end else m_cnt++;
          end
          default: begin
            if (m_s2) begin
              m_hi++;
              if (sync_mode || m_hi >= 2) begin ev = 1; m_st = 0; m_hi = 0; end
            end else m_hi = 0;
          end
        endcase
      end
      if (ev) m_flag = 1;
      else if (stat_clr) m_flag = 0;
      m_s2 = m_s1;
      m_s1 = rxd_in;
    end
  end

  int         n_valid = 0;
  logic [7:0] last_data = 0;

  always @(negedge clk) begin
    if (cmp_on) begin
      check(rx_valid == m_valid, "R3 rx_valid", rx_valid, m_valid);
      check(rx_data == m_data, "R3 rx_data", rx_data, m_data);
      check(frame_err == m_fe, "R5 frame_err", frame_err, m_fe);
      check(par_err == m_pe, "R4 par_err", par_err, m_pe);
      check(brk_flag == m_flag, "R11 brk_flag", brk_flag, m_flag);
      if (rx_valid) begin n_valid++; last_data = rx_data; end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic hold(input logic b, input int ticks);
    rxd_in = b;
    for (int i = 0; i < ticks; i++) begin
      @(posedge clk);
      while (!tick16) @(posedge clk);
    end
    @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic pb, input logic stopb);
    hold(1'b0, 16);
    for (int i = 0; i < 8; i++) hold(d[i], 16);
    if (par_en) hold(pb, 16);
    hold(stopb, 16);
    hold(1'b1, 32);
  endtask

  task automatic pulse_clr();
    stat_clr = 1'b1;
    @(negedge clk);
    stat_clr = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    int nv;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    cmp_on = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(rx_valid == 0 && frame_err == 0 && par_err == 0, "R1 reset outputs", {rx_valid, frame_err, par_err}, 0);
    check(brk_flag == 0 && rx_data == 8'h00, "R1 reset flag/data", {brk_flag, rx_data}, 0);
    hold(1'b1, 8);

    // R3 plain character
    nv = n_valid;
    send_frame(8'hA5, 1'b0, 1'b1);
    check(n_valid == nv + 1 && last_data == 8'hA5, "R3 byte A5", last_data, 8'hA5);
    check(frame_err == 0, "R5 good stop", frame_err, 0);
    send_frame(8'h01, 1'b0, 1'b1);
    check(last_data == 8'h01, "R3 lsb first", last_data, 8'h01);

    // R4 parity
    par_en = 1'b1;
    send_frame(8'h3C, 1'b0, 1'b1);
    check(par_err == 0 && last_data == 8'h3C, "R4 even ok", par_err, 0);
    send_frame(8'h3D, 1'b0, 1'b1);
    check(par_err == 1, "R4 even bad", par_err, 1);
    par_odd = 1'b1;
    send_frame(8'h3D, 1'b0, 1'b1);
    check(par_err == 0, "R4 odd ok", par_err, 0);

    // R5 framing error, and all-zero data with parity bit set is not a break
    par_odd = 1'b0;
    send_frame(8'h5A, 1'b0, 1'b0);
    check(frame_err == 1 && last_data == 8'h5A, "R5 low stop", frame_err, 1);
    nv = n_valid;
    send_frame(8'h00, 1'b1, 1'b0);
    check(n_valid == nv + 1 && frame_err == 1 && brk_flag == 0, "R6 parity-set zero frame", {frame_err, brk_flag}, 2);
    par_en = 1'b0;

    // R2 false start
    nv = n_valid;
    hold(1'b0, 4);
    hold(1'b1, 40);
    check(n_valid == nv, "R2 false start", n_valid, nv);
    send_frame(8'hC3, 1'b0, 1'b1);
    check(last_data == 8'hC3, "R2 recover", last_data, 8'hC3);

    // R6, R7, R8, R10 async break
    nv = n_valid;
    hold(1'b0, 16 * 10);
    check(brk_flag == 1 && frame_err == 0, "R6 break start", {brk_flag, frame_err}, 2);
    check(n_valid == nv, "R6 no valid on break", n_valid, nv);
    pulse_clr();
    check(brk_flag == 0, "R11 clear", brk_flag, 0);
    hold(1'b0, 64);
    hold(1'b1, 1);
    hold(1'b0, 16);
    check(brk_flag == 0, "R8 single high ignored", brk_flag, 0);
    check(n_valid == nv, "R7 no start in break", n_valid, nv);
    hold(1'b1, 24);
    check(brk_flag == 1, "R10 break end", brk_flag, 1);
    pulse_clr();
    send_frame(8'h7E, 1'b0, 1'b1);
    check(last_data == 8'h7E && n_valid == nv + 1, "R10 receive after break", last_data, 8'h7E);

    // R9 sync end, R11 clear held across the event
    sync_mode = 1'b1;
    hold(1'b0, 16 * 10);
    check(brk_flag == 1, "R6 break start sync", brk_flag, 1);
    stat_clr = 1'b1;
    hold(1'b0, 8);
    check(brk_flag == 0, "R11 clear held", brk_flag, 0);
    hold(1'b1, 1);
    stat_clr = 1'b0;
    hold(1'b1, 20);
    check(n_valid == nv + 1, "R9 no spurious char", n_valid, nv + 1);
    sync_mode = 1'b0;
    send_frame(8'h96, 1'b0, 1'b1);
    check(last_data == 8'h96, "R9 receive after sync end", last_data, 8'h96);

    // R9 break end not missed: set flag persists
    sync_mode = 1'b1;
    hold(1'b0, 16 * 10);
    pulse_clr();
    hold(1'b1, 1);
    hold(1'b1, 4);
    check(brk_flag == 1, "R9 one high sample", brk_flag, 1);
    sync_mode = 1'b0;

    hold(1'b1, 16);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule